// File: doc/BRIEF.md
# Host Register Port with Task Handshake

This block is the host-facing side of a packet modem. A byte-wide host bus with a two-bit register select, an active-low chip select and separate active-low read and write strobes reaches a small, asymmetric register map. Writes go to a data buffer, a command register, a control register and a mode register. Reads return the data buffer, a status byte and a data-quality byte.

The data buffer holds eighteen bytes but occupies one address. An internal pointer steps through it on every host access. A command write that carries a task code hands the buffer to the modem engine through a request/done port. It also clears the buffer-free flag. When the engine reports that it has drained the buffer (transmit) or filled it (receive), the buffer-free and interrupt flags are both raised. Host strobes are sampled on the block clock. Each access takes effect on the clock edge that sees its strobe return high. The bidirectional data bus and the open-drain interrupt line appear as output-enable signals for the pad ring.

Top module: `hif_host_port`

## Requirements
- R1: A write with `haddr`=00 stores into the data buffer, 01 into the command register, 10 into the control register (`ctrl_q`) and 11 into the mode register (`mode_q`).
- R2: A read with `haddr`=01 returns the status byte {irq flag in bit 7, buffer-free in bit 6, `eng_stat` in bits 5..0}. A read at 10 returns `quality_in`, a read at 11 returns 0x00, and a read at 00 returns the buffer byte at the pointer.
- R3: Every host buffer access moves the pointer to the next byte, and the pointer wraps from byte 17 to byte 0. The pointer returns to byte 0 on any task write and on an accepted engine done.
- R4: A command write whose task field (bits 2..0) is neither 000 (null) nor 111 (reset) clears buffer-free and raises `eng_req` from the next cycle. The same write places the code on `eng_task`.
- R5: `eng_done` while `eng_req` is high sets buffer-free and the irq flag and drops `eng_req` on the next cycle.
- R6: `hirq_oe` is high only while the irq flag is set and mode bit 7 is 1. A status read clears the irq flag.
- R7: `eng_done` while `eng_req` is low has no effect on the flags or the request.
- R8: A command write with bit 7 at 1 gives a one-cycle `acq_clk_pulse`, and one with bit 6 at 1 gives a one-cycle `acq_lev_pulse`. Neither pulse occurs when the task field is 111, and a bit written as 0 gives no pulse.
- R9: The reset task (111) clears the irq flag and `eng_req`, sets buffer-free and returns the pointer to byte 0.
- R10: An access counts only when `hwr_n` or `hrd_n` rises while `hcs_n` is low. `hdout_oe` is high only while `hcs_n` and `hrd_n` are both low. Strobes without chip select change no state.
- R11: The engine writes buffer byte `eng_addr` when `eng_we` is high, and `eng_rdata` always shows byte `eng_addr`. After reset, buffer-free is 1, the irq flag is 0, `eng_req` is 0, and `ctrl_q` and `mode_q` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hcs_n | input | 1 | Host chip select, active low |
| hwr_n | input | 1 | Host write strobe, active low |
| hrd_n | input | 1 | Host read strobe, active low |
| haddr | input | 2 | Register select |
| hdin | input | 8 | Host write data |
| hdout | output | 8 | Host read data |
| hdout_oe | output | 1 | Enable for the host data bus drivers |
| hirq_oe | output | 1 | Pull-down enable for the open-drain interrupt line |
| ctrl_q | output | 8 | Control register contents |
| mode_q | output | 8 | Mode register contents; bit 7 enables the interrupt |
| quality_in | input | 8 | Data-quality value returned to the host |
| eng_stat | input | 6 | Engine status bits shown in the status byte |
| eng_req | output | 1 | Task pending for the engine |
| eng_task | output | 3 | Code of the pending task |
| eng_done | input | 1 | Engine has drained or filled the buffer |
| eng_addr | input | 5 | Engine buffer index |
| eng_we | input | 1 | Engine buffer write enable |
| eng_wdata | input | 8 | Engine buffer write data |
| eng_rdata | output | 8 | Buffer byte at `eng_addr` |
| acq_clk_pulse | output | 1 | Restart pulse for bit-clock acquisition |
| acq_lev_pulse | output | 1 | Restart pulse for level acquisition |

## Verification
The bench builds the block with its default eight-bit data path and eighteen-byte buffer. At that depth a loop of nineteen host accesses crosses the wrap from byte 17 back to byte 0, and the bench confirms the wrap both on the engine side and on host reads. The full-width status byte lets the bench see the irq flag, buffer-free and the engine status bits together. Transmit and receive hand-offs, stray done pulses, a reset task issued mid-task and strobes without chip select are all compared against a behavioural model on every clock.

// File: rtl/hif_pkg.sv
// Shared register-select codes, task codes and command bit positions
// for the host register port. Assumes an 8-bit command byte.
package hif_pkg;
    typedef enum logic [1:0] {
        SEL_DATA = 2'b00,
        SEL_CMD  = 2'b01,
        SEL_CTRL = 2'b10,
        SEL_MODE = 2'b11
    } hif_sel_e;

    localparam logic [2:0] TASK_NULL  = 3'b000;
    localparam logic [2:0] TASK_RESET = 3'b111;

    localparam int CMD_ACQ_CLK_BIT = 7;
    localparam int CMD_ACQ_LEV_BIT = 6;
    localparam int MODE_IRQEN_BIT  = 7;
endpackage

// File: rtl/hif_strobe.sv
// Turns the host strobes into one-cycle access events.
// Assumes the host strobes are synchronous to clk. An access fires on the
// clock edge that sees the strobe high after it was low, with chip select low.
module hif_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic wr_n,
    input  logic rd_n,
    output logic wr_evt,
    output logic rd_evt
);
    logic wr_q;
    logic rd_q;

    // Remember the previous level of each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q <= 1'b1;
            rd_q <= 1'b1;
        end else begin
            wr_q <= wr_n;
            rd_q <= rd_n;
        end
    end

    // A rising strobe under chip select marks the end of an access.
    always_comb begin
        wr_evt = !wr_q && wr_n && !cs_n;
        rd_evt = !rd_q && rd_n && !cs_n;
    end
endmodule

// File: rtl/hif_buffer.sv
// Single-address data buffer shared between the host and the engine.
// The host side steps an internal pointer on each access and wraps at DEPTH.
// The engine side is random access. Engine writes win over host writes to
// the same byte, although the handshake keeps the two sides apart.
module hif_buffer #(
    parameter int DW    = 8,
    parameter int DEPTH = 18,
    parameter int PW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_we,
    input  logic          host_re,
    input  logic          ptr_clr,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    input  logic [PW-1:0] eng_addr,
    input  logic          eng_we,
    input  logic [DW-1:0] eng_wdata,
    output logic [DW-1:0] eng_rdata
);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    logic [PW-1:0] ptr;
    logic [DW-1:0] mem [DEPTH];

    // Host pointer: clear on a hand-off, step on each host access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (ptr_clr) begin
            ptr <= '0;
        end else if (host_we || host_re) begin
            ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
        end
    end

    // One storage byte per entry, written by the engine or the host.
    for (genvar i = 0; i < DEPTH; i++) begin : g_byte
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem[i] <= '0;
            end else if (eng_we && eng_addr == PW'(i)) begin
                mem[i] <= eng_wdata;
            end else if (host_we && ptr == PW'(i)) begin
                mem[i] <= host_wdata;
            end
        end
    end

    // Read ports: the host sees the pointed byte, the engine its own index.
    always_comb begin
        host_rdata = mem[ptr];
        eng_rdata  = (eng_addr <= LAST) ? mem[eng_addr] : '0;
    end

    AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ptr <= LAST); // R3
    AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (host_re && ptr == LAST && !ptr_clr) |=> ptr == '0); // R3
endmodule

// File: rtl/hif_taskctl.sv
// Command decode and task handshake: buffer-free and irq flags, the engine
// request, and the acquisition restart pulses. Assumes cmd_we and stat_re
// are single-cycle events, never on consecutive cycles.
module hif_taskctl
    import hif_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_we,
    input  logic [DW-1:0] cmd_data,
    input  logic          stat_re,
    input  logic          eng_done,
    output logic          bfree,
    output logic          irq_flag,
    output logic          eng_req,
    output logic [2:0]    eng_task,
    output logic          acq_clk,
    output logic          acq_lev,
    output logic          ptr_clr
);
    logic [2:0] code;
    logic       is_reset;
    logic       is_start;
    logic       done_ok;

    // Classify the command byte being written.
    always_comb begin
        code     = cmd_data[2:0];
        is_reset = cmd_we && (code == TASK_RESET);
        is_start = cmd_we && (code != TASK_NULL) && (code != TASK_RESET);
        done_ok  = eng_done && eng_req;
        ptr_clr  = is_reset || is_start || done_ok;
    end

    // Handshake flags and the engine request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bfree    <= 1'b1;
            irq_flag <= 1'b0;
            eng_req  <= 1'b0;
            eng_task <= TASK_NULL;
        end else if (is_reset) begin
            bfree    <= 1'b1;
            irq_flag <= 1'b0;
            eng_req  <= 1'b0;
        end else begin
            if (stat_re) irq_flag <= 1'b0;
            if (is_start) begin
                bfree    <= 1'b0;
                eng_req  <= 1'b1;
                eng_task <= code;
            end else if (done_ok) begin
                bfree    <= 1'b1;
                irq_flag <= 1'b1;
                eng_req  <= 1'b0;
            end
        end
    end

    // One-cycle acquisition restart pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acq_clk <= 1'b0;
            acq_lev <= 1'b0;
        end else begin
            acq_clk <= cmd_we && cmd_data[CMD_ACQ_CLK_BIT] && (code != TASK_RESET);
            acq_lev <= cmd_we && cmd_data[CMD_ACQ_LEV_BIT] && (code != TASK_RESET);
        end
    end

    AST_START_CLEARS_BFREE: assert property (@(posedge clk) disable iff (!rst_n)
        is_start |=> !bfree && eng_req); // R4
    AST_DONE_SETS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (done_ok && !cmd_we) |=> bfree && irq_flag && !eng_req); // R5
    AST_STRAY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_done && !eng_req && !cmd_we) |=> $stable(bfree) && $stable(eng_req)); // R7
    AST_ACQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (acq_clk || acq_lev) |=> !acq_clk && !acq_lev); // R8
    AST_RESET_TASK: assert property (@(posedge clk) disable iff (!rst_n)
        is_reset |=> bfree && !irq_flag && !eng_req && !acq_clk && !acq_lev); // R9
endmodule

// File: rtl/hif_host_port.sv
// Top of the host register port: event detection, the control and mode
// registers, the read multiplexer, and the bus and interrupt enables.
// Assumes the pad ring turns hdout_oe into a tri-state driver and hirq_oe
// into an open-drain pull-down.
module hif_host_port
    import hif_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DEPTH = 18,
    parameter int PW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hcs_n,
    input  logic          hwr_n,
    input  logic          hrd_n,
    input  logic [1:0]    haddr,
    input  logic [DW-1:0] hdin,
    output logic [DW-1:0] hdout,
    output logic          hdout_oe,
    output logic          hirq_oe,
    output logic [DW-1:0] ctrl_q,
    output logic [DW-1:0] mode_q,
    input  logic [DW-1:0] quality_in,
    input  logic [DW-3:0] eng_stat,
    output logic          eng_req,
    output logic [2:0]    eng_task,
    input  logic          eng_done,
    input  logic [PW-1:0] eng_addr,
    input  logic          eng_we,
    input  logic [DW-1:0] eng_wdata,
    output logic [DW-1:0] eng_rdata,
    output logic          acq_clk_pulse,
    output logic          acq_lev_pulse
);
    hif_sel_e      sel;
    logic          wr_evt;
    logic          rd_evt;
    logic          bfree;
    logic          irq_flag;
    logic          ptr_clr;
    logic [DW-1:0] buf_rdata;

    assign sel = hif_sel_e'(haddr);

    hif_strobe u_strobe (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs_n   (hcs_n),
        .wr_n   (hwr_n),
        .rd_n   (hrd_n),
        .wr_evt (wr_evt),
        .rd_evt (rd_evt)
    );

    hif_buffer #(.DW(DW), .DEPTH(DEPTH), .PW(PW)) u_buffer (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (wr_evt && sel == SEL_DATA),
        .host_re    (rd_evt && sel == SEL_DATA),
        .ptr_clr    (ptr_clr),
        .host_wdata (hdin),
        .host_rdata (buf_rdata),
        .eng_addr   (eng_addr),
        .eng_we     (eng_we),
        .eng_wdata  (eng_wdata),
        .eng_rdata  (eng_rdata)
    );

    hif_taskctl #(.DW(DW)) u_taskctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_we   (wr_evt && sel == SEL_CMD),
        .cmd_data (hdin),
        .stat_re  (rd_evt && sel == SEL_CMD),
        .eng_done (eng_done),
        .bfree    (bfree),
        .irq_flag (irq_flag),
        .eng_req  (eng_req),
        .eng_task (eng_task),
        .acq_clk  (acq_clk_pulse),
        .acq_lev  (acq_lev_pulse),
        .ptr_clr  (ptr_clr)
    );

    // Control and mode registers, written by host write events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            mode_q <= '0;
        end else if (wr_evt) begin
            if (sel == SEL_CTRL) ctrl_q <= hdin;
            if (sel == SEL_MODE) mode_q <= hdin;
        end
    end

    // Read multiplexer and bus/interrupt enables.
    always_comb begin
        unique case (sel)
            SEL_DATA: hdout = buf_rdata;
            SEL_CMD:  hdout = {irq_flag, bfree, eng_stat};
            SEL_CTRL: hdout = quality_in;
            default:  hdout = '0;
        endcase
        hdout_oe = !hcs_n && !hrd_n;
        hirq_oe  = irq_flag && mode_q[MODE_IRQEN_BIT];
    end

    AST_STATUS_READ_RELEASES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_evt && sel == SEL_CMD && !(eng_done && eng_req)) |=> !hirq_oe); // R6
    AST_NO_WRITE_WITHOUT_CS: assert property (@(posedge clk) disable iff (!rst_n)
        hcs_n |=> $stable(ctrl_q) && $stable(mode_q)); // R10
endmodule

// File: tb/hif_host_port_tb.sv
// Bench for hif_host_port: a behavioural model kept in integers and arrays,
// compared with the registered outputs on every falling clock edge.
module hif_host_port_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hcs_n = 1'b1, hwr_n = 1'b1, hrd_n = 1'b1;
    logic [1:0] haddr = 2'b00;
    logic [7:0] hdin = 8'h00;
    logic [7:0] hdout;
    logic       hdout_oe, hirq_oe;
    logic [7:0] ctrl_q, mode_q;
    logic [7:0] quality_in = 8'h3C;
    logic [5:0] eng_stat = 6'h15;
    logic       eng_req;
    logic [2:0] eng_task;
    logic       eng_done = 1'b0;
    logic [4:0] eng_addr = 5'd0;
    logic       eng_we = 1'b0;
    logic [7:0] eng_wdata = 8'h00;
    logic [7:0] eng_rdata;
    logic       acq_clk_pulse, acq_lev_pulse;

    int checks = 0;
    int errors = 0;
    int n_acq_clk = 0;
    int n_acq_lev = 0;
    bit model_on = 0;

    int m_irq, m_bfree, m_req, m_ptr;
    int m_ctrl, m_mode;
    int m_mem [18];

    always #10 clk = ~clk;

    hif_host_port u_dut (
        .clk(clk), .rst_n(rst_n), .hcs_n(hcs_n), .hwr_n(hwr_n), .hrd_n(hrd_n),
        .haddr(haddr), .hdin(hdin), .hdout(hdout), .hdout_oe(hdout_oe),
        .hirq_oe(hirq_oe), .ctrl_q(ctrl_q), .mode_q(mode_q),
        .quality_in(quality_in), .eng_stat(eng_stat), .eng_req(eng_req),
        .eng_task(eng_task), .eng_done(eng_done), .eng_addr(eng_addr),
        .eng_we(eng_we), .eng_wdata(eng_wdata), .eng_rdata(eng_rdata),
        .acq_clk_pulse(acq_clk_pulse), .acq_lev_pulse(acq_lev_pulse)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (acq_clk_pulse) n_acq_clk++;
        if (acq_lev_pulse) n_acq_lev++;
    end

    // Compare the model with the registered outputs every cycle.
    always @(negedge clk) begin
        if (model_on) begin
            check("R6 irq_oe", int'(hirq_oe), (m_irq != 0 && m_mode[7]) ? 1 : 0);
            check("R4 eng_req", int'(eng_req), m_req);
            check("R1 ctrl_q", int'(ctrl_q), m_ctrl);
            check("R1 mode_q", int'(mode_q), m_mode);
        end
    end

    function automatic void step_ptr();
        m_ptr = (m_ptr == 17) ? 0 : m_ptr + 1;
    endfunction

    task automatic host_wr(input int a, input int d, input bit cs = 1);
        @(negedge clk);
        hcs_n = !cs; haddr = 2'(a); hdin = 8'(d); hwr_n = 1'b0;
        @(negedge clk);
        hwr_n = 1'b1;
        @(posedge clk);
        if (cs) begin
            case (a)
                0: begin m_mem[m_ptr] = d & 255; step_ptr(); end
                1: begin
                    if ((d & 7) == 7) begin
                        m_bfree = 1; m_irq = 0; m_req = 0; m_ptr = 0;
                    end else if ((d & 7) != 0) begin
                        m_bfree = 0; m_req = 1; m_ptr = 0;
                    end
                end
                2: m_ctrl = d & 255;
                default: m_mode = d & 255;
            endcase
        end
        @(negedge clk);
        hcs_n = 1'b1;
    endtask

    task automatic host_rd(input int a, input string req, output int val);
        int exp;
        @(negedge clk);
        hcs_n = 1'b0; haddr = 2'(a); hrd_n = 1'b0;
        @(negedge clk);
        val = int'(hdout);
        check("R10 oe during read", int'(hdout_oe), 1);
        case (a)
            0: exp = m_mem[m_ptr];
            1: exp = (m_irq << 7) | (m_bfree << 6) | 'h15;
            2: exp = 'h3C;
            default: exp = 0;
        endcase
        check(req, val, exp);
        hrd_n = 1'b1;
        @(posedge clk);
        if (a == 0) step_ptr();
        if (a == 1) m_irq = 0;
        @(negedge clk);
        hcs_n = 1'b1;
    endtask

    task automatic eng_finish();
        @(negedge clk);
        eng_done = 1'b1;
        @(posedge clk);
        if (m_req != 0) begin
            m_bfree = 1; m_irq = 1; m_req = 0; m_ptr = 0;
        end
        @(negedge clk);
        eng_done = 1'b0;
    endtask

    task automatic eng_write(input int a, input int d);
        @(negedge clk);
        eng_addr = 5'(a); eng_wdata = 8'(d); eng_we = 1'b1;
        @(posedge clk);
        m_mem[a] = d & 255;
        @(negedge clk);
        eng_we = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int v;
        int c0, l0;
        m_irq = 0; m_bfree = 1; m_req = 0; m_ptr = 0; m_ctrl = 0; m_mode = 0;
        for (int i = 0; i < 18; i++) m_mem[i] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_on = 1;

        // R11 reset state, R2 status layout
        host_rd(1, "R11 reset status", v);
        check("R2 status value", v, 'h55);

        // R1 control and mode, R2 other reads
        host_wr(3, 'h80);
        host_wr(2, 'hA5);
        host_rd(2, "R2 quality read", v);
        host_rd(3, "R2 unused address reads zero", v);

        // R10 strobes without chip select are ignored
        host_wr(2, 'h11, 0);
        check("R10 ctrl unchanged", int'(ctrl_q), 'hA5);
        @(negedge clk);
        hrd_n = 1'b0;
        #1 check("R10 no drive without cs", int'(hdout_oe), 0);
        @(negedge clk);
        hrd_n = 1'b1;

        // R3 fill 18 bytes plus one that wraps onto byte 0, R11 engine view
        for (int i = 0; i < 19; i++) host_wr(0, i * 7 + 2);
        for (int i = 0; i < 18; i++) begin
            @(negedge clk);
            eng_addr = 5'(i);
            #1 check("R3 R11 engine sees host byte", int'(eng_rdata), m_mem[i]);
        end
        check("R3 wrap overwrote byte 0", m_mem[0], 18 * 7 + 2);

        // R4 transmit task hand-off
        host_wr(1, 'h02);
        check("R4 eng_task", int'(eng_task), 2);
        host_rd(1, "R4 status busy", v);
        // R5 engine drains the buffer, R6 irq asserted then released
        eng_finish();
        check("R6 irq pulled", int'(hirq_oe), 1);
        host_rd(1, "R5 status after done", v);
        check("R5 status bits", v, 'hD5);
        check("R6 irq released", int'(hirq_oe), 0);

        // R7 stray done while idle
        eng_finish();
        host_rd(1, "R7 stray done ignored", v);

        // Receive: engine fills, host reads 18 bytes and a wrapped 19th
        host_wr(1, 'h03);
        for (int i = 0; i < 18; i++) eng_write(i, i * 3 + 1);
        eng_finish();
        for (int i = 0; i < 19; i++) host_rd(0, "R3 R11 host reads engine data", v);
        check("R3 19th read is byte 0", v, 1);
        host_rd(1, "R6 status clears irq", v);

        // R6 irq masked when mode bit 7 is 0
        host_wr(3, 'h00);
        host_wr(1, 'h04);
        eng_finish();
        check("R6 masked irq", int'(hirq_oe), 0);
        host_rd(1, "R6 flag still visible", v);

        // R8 acquisition pulses
        c0 = n_acq_clk; l0 = n_acq_lev;
        host_wr(1, 'hC0);
        repeat (2) @(negedge clk);
        check("R8 clock pulse count", n_acq_clk - c0, 1);
        check("R8 level pulse count", n_acq_lev - l0, 1);
        host_wr(1, 'h40);
        repeat (2) @(negedge clk);
        check("R8 zero bit gives no pulse", n_acq_clk - c0, 1);
        check("R8 level pulse again", n_acq_lev - l0, 2);

        // R9 reset task aborts a pending task, no pulses with it
        host_wr(1, 'h05);
        host_wr(0, 'h99);
        host_wr(1, 'hC7);
        repeat (2) @(negedge clk);
        check("R9 R8 no pulse on reset task", n_acq_clk - c0, 1);
        host_rd(1, "R9 status after reset task", v);
        host_rd(0, "R9 pointer at byte 0", v);

        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule